// File: doc/BRIEF.md
# Configuration Lock Key Sequencer

This block guards the per-pin configuration of an I/O port. It monitors bus accesses to a single lock register, and a lock mask is staged in bits 15:0 of that register. The mask takes effect only after a key handshake completes on bit 16, and every access in that handshake is a full-word access. The handshake is three writes followed by one read. Once the handshake completes, the key status bit becomes sticky. The block then drives the staged mask as a freeze mask, which the configuration registers use to reject writes to the locked pins' fields.

The bus side of the block has a strobe, a lock-register select, a write flag, an access size and the write data. Read data is always presented for the lock register. Accesses to any other register, marked by a low select, leave the block untouched. Any wrong access to the lock register in the middle of the handshake sends the sequencer back to idle without locking. Only a reset clears the lock.

Top module: `cfg_lock_seq`

## Requirements
- R1: `rdata_o` shows the key status in bit 16 and the staged lock bits in bits 15:0. Bits 31:17 always read zero.
- R2: The key becomes active on the clock edge of the fourth step of a handshake, and the freeze mask then equals M. The four steps go to the lock register with size 2'b10 (word): a write with bit 16 = 1 and bits 15:0 = M, a write with bit 16 = 0 and the same M, a write with bit 16 = 1 and the same M, then a read.
- R3: A byte access (size 2'b00) or halfword access (size 2'b01) to the lock register never counts toward the handshake. It aborts a handshake in progress and does not change the staged lock bits.
- R4: The attempt is aborted and the key stays 0 if the lock bits change between handshake writes. The same holds if the steps arrive out of order, for example a read before the third write or two key-one writes in a row.
- R5: Once the key is active, it and the lock bits hold their values until reset. Later writes to the lock register have no effect.
- R6: While the key is 0, every word write to the lock register loads bits 15:0 into the staged lock bits, in any sequencer state.
- R7: `lock_mask_o` is all zero while the key is 0.
- R8: After reset, the key, the staged lock bits, the freeze mask and the sequence state are all zero.
- R9: Accesses with `acc_sel_i` low neither advance nor abort the handshake, and they change nothing visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Bus access strobe, one cycle per access |
| acc_sel_i | input | 1 | Access targets the lock register |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_size_i | input | 2 | 00 byte, 01 halfword, 10 word |
| acc_wdata_i | input | 32 | Write data |
| lock_mask_o | output | 16 | Per-pin freeze mask for configuration fields |
| key_active_o | output | 1 | Sticky lock key status |
| rdata_o | output | 32 | Lock register read value |

## Verification
The checker watches these properties on every cycle:
- The key and freeze mask are sticky.
- The freeze mask is zero while unlocked.
- The reserved bits read zero.
- The key only rises right after a word read of the lock register.
- Narrow accesses and accesses to other registers leave the register image unchanged.
- Word writes load the staged bits while unlocked.

Only the bench scenarios can show the handshake itself. They complete it in order, abort it through a changed mask, a narrow access or a misordered step, interleave foreign accesses, and confirm that the lock survives later rewrite attempts.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ARM1 = 2'd1,
    SEQ_ARM2 = 2'd2,
    SEQ_ARM3 = 2'd3
  } seq_state_t;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode #(
  parameter int NPINS = 16
) (
  input  logic             valid_i,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [1:0]       size_i,
  input  logic [NPINS:0]   wdata_i,
  input  logic [NPINS-1:0] staged_i,
  output logic             hit_o,
  output logic             word_wr_o,
  output logic             word_rd_o,
  output logic             key_one_o,
  output logic             same_mask_o
);
  import cfg_lock_pkg::*;
  logic word;
  assign hit_o       = valid_i && sel_i;
  assign word        = (size_i == SZ_WORD);
  assign word_wr_o   = hit_o && word && we_i;
  assign word_rd_o   = hit_o && word && !we_i;
  assign key_one_o   = wdata_i[NPINS];
  assign same_mask_o = (wdata_i[NPINS-1:0] == staged_i);
endmodule

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic locked_i,
  input  logic hit_i,
  input  logic word_wr_i,
  input  logic word_rd_i,
  input  logic key_one_i,
  input  logic same_mask_i,
  output logic commit_o
);
  import cfg_lock_pkg::*;
  seq_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    commit_o = 1'b0;
    if (locked_i) begin
      state_d = SEQ_IDLE;
    end else if (hit_i) begin
      // any lock-register access that is not the expected step returns to idle
      state_d = SEQ_IDLE;
      unique case (state_q)
        SEQ_IDLE: if (word_wr_i && key_one_i) state_d = SEQ_ARM1;
        SEQ_ARM1: if (word_wr_i && !key_one_i && same_mask_i) state_d = SEQ_ARM2;
        SEQ_ARM2: if (word_wr_i && key_one_i && same_mask_i) state_d = SEQ_ARM3;
        SEQ_ARM3: if (word_rd_i) commit_o = 1'b1;
        default:  state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store #(
  parameter int NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_wr_i,
  input  logic [NPINS-1:0] wmask_i,
  input  logic             commit_i,
  output logic [NPINS-1:0] staged_o,
  output logic             key_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_o <= '0;
      key_o    <= 1'b0;
    end else if (!key_o) begin
      if (word_wr_i) staged_o <= wmask_i;
      if (commit_i)  key_o    <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq #(
  parameter int NPINS = 16,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_sel_i,
  input  logic             acc_we_i,
  input  logic [1:0]       acc_size_i,
  input  logic [DW-1:0]    acc_wdata_i,
  output logic [NPINS-1:0] lock_mask_o,
  output logic             key_active_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int KEY_BIT = NPINS;
  localparam int RSV_W   = DW - KEY_BIT - 1;

  logic             hit, word_wr, word_rd, key_one, same_mask, commit, key_q;
  logic [NPINS-1:0] staged_q;

  cfg_lock_decode #(.NPINS(NPINS)) u_dec (
    .valid_i    (acc_valid_i),
    .sel_i      (acc_sel_i),
    .we_i       (acc_we_i),
    .size_i     (acc_size_i),
    .wdata_i    (acc_wdata_i[KEY_BIT:0]),
    .staged_i   (staged_q),
    .hit_o      (hit),
    .word_wr_o  (word_wr),
    .word_rd_o  (word_rd),
    .key_one_o  (key_one),
    .same_mask_o(same_mask)
  );

  cfg_lock_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .locked_i   (key_q),
    .hit_i      (hit),
    .word_wr_i  (word_wr),
    .word_rd_i  (word_rd),
    .key_one_i  (key_one),
    .same_mask_i(same_mask),
    .commit_o   (commit)
  );

  cfg_lock_store #(.NPINS(NPINS)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .word_wr_i(word_wr),
    .wmask_i  (acc_wdata_i[NPINS-1:0]),
    .commit_i (commit),
    .staged_o (staged_q),
    .key_o    (key_q)
  );

  assign key_active_o = key_q;
  assign lock_mask_o  = key_q ? staged_q : '0;
  assign rdata_o      = {{RSV_W{1'b0}}, key_q, staged_q};
endmodule

// File: rtl/cfg_lock_seq_chk.sv
module cfg_lock_seq_chk #(
  parameter int NPINS = 16,
  parameter int DW    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             acc_sel_i,
  input logic             acc_we_i,
  input logic [1:0]       acc_size_i,
  input logic [NPINS-1:0] wmask_i,
  input logic [NPINS-1:0] lock_mask_o,
  input logic             key_active_o,
  input logic [DW-1:0]    rdata_o
);
  localparam int KEY_BIT = NPINS;

  assert_rsv_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:KEY_BIT+1] == '0);

  assert_key_on_word_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(key_active_o) |-> $past(acc_valid_i && acc_sel_i && !acc_we_i && acc_size_i == 2'b10));

  assert_narrow_no_effect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_sel_i && acc_size_i != 2'b10) |=> $stable(rdata_o));

  assert_key_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_active_o |=> (key_active_o && $stable(lock_mask_o)));

  assert_stage_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_sel_i && acc_we_i && acc_size_i == 2'b10 && !key_active_o)
      |=> rdata_o[NPINS-1:0] == $past(wmask_i));

  assert_no_freeze_unlocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_active_o |-> lock_mask_o == '0);

  assert_foreign_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_valid_i && acc_sel_i) |=> $stable(rdata_o));
endmodule

bind cfg_lock_seq cfg_lock_seq_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_sel_i   (acc_sel_i),
  .acc_we_i    (acc_we_i),
  .acc_size_i  (acc_size_i),
  .wmask_i     (acc_wdata_i[NPINS-1:0]),
  .lock_mask_o (lock_mask_o),
  .key_active_o(key_active_o),
  .rdata_o     (rdata_o)
);

// File: tb/sim_cfg_lock_seq.sv
`timescale 1ns/1ps
module sim_cfg_lock_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, sel = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'b10;
  logic [31:0] wdata = '0;
  logic [15:0] mask;
  logic        key;
  logic [31:0] rdata;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cfg_lock_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_sel_i(sel),
    .acc_we_i(we), .acc_size_i(size), .acc_wdata_i(wdata),
    .lock_mask_o(mask), .key_active_o(key), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    valid = 0; rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // one-cycle access driven at negedge; returns at next negedge (after the edge)
  task automatic acc(input logic s, input logic w, input logic [1:0] sz, input logic [31:0] d);
    valid = 1; sel = s; we = w; size = sz; wdata = d;
    @(negedge clk);
    valid = 0; sel = 0; we = 0; wdata = '0;
  endtask

  task automatic wr(input logic [31:0] d); acc(1, 1, 2'b10, d); endtask
  task automatic rd(); acc(1, 0, 2'b10, '0); endtask

  task automatic t_reset();
    do_reset();
    chk("R8 rdata", rdata, 32'h0);
    chk("R8 key", {31'b0, key}, 32'h0);
    chk("R8 mask", {16'b0, mask}, 32'h0);
  endtask

  task automatic t_good();
    do_reset();
    wr(32'h0001_A5C3); wr(32'h0000_A5C3); wr(32'h0001_A5C3);
    chk("R7 mask before read", {16'b0, mask}, 32'h0);
    chk("R2 key before read", {31'b0, key}, 32'h0);
    rd();
    chk("R2 key", {31'b0, key}, 32'h1);
    chk("R2 mask", {16'b0, mask}, 32'h0000_A5C3);
    chk("R1 rdata", rdata, 32'h0001_A5C3);
  endtask

  task automatic t_sticky();
    // continues from a locked state
    wr(32'h0000_1234);
    chk("R5 rewrite", rdata, 32'h0001_A5C3);
    wr(32'h0001_00FF); wr(32'h0000_00FF); wr(32'h0001_00FF); rd();
    chk("R5 relock mask", {16'b0, mask}, 32'h0000_A5C3);
    chk("R5 key", {31'b0, key}, 32'h1);
  endtask

  task automatic t_mask_change();
    do_reset();
    wr(32'h0001_1111); wr(32'h0000_2222); wr(32'h0001_2222); rd();
    chk("R4 changed mask key", {31'b0, key}, 32'h0);
    chk("R6 staged follows write", rdata, 32'h0000_2222);
  endtask

  task automatic t_narrow();
    do_reset();
    wr(32'h0001_0F0F); wr(32'h0000_0F0F);
    acc(1, 1, 2'b01, 32'h0001_FFFF);
    chk("R3 half write no stage", rdata, 32'h0000_0F0F);
    wr(32'h0001_0F0F); rd();
    chk("R3 half aborts", {31'b0, key}, 32'h0);
    do_reset();
    wr(32'h0001_0F0F); wr(32'h0000_0F0F); wr(32'h0001_0F0F);
    acc(1, 0, 2'b00, '0);
    chk("R3 byte read no key", {31'b0, key}, 32'h0);
    rd();
    chk("R3 later read no key", {31'b0, key}, 32'h0);
  endtask

  task automatic t_order();
    do_reset();
    wr(32'h0001_3C3C); wr(32'h0001_3C3C); wr(32'h0000_3C3C); rd();
    chk("R4 misorder key", {31'b0, key}, 32'h0);
    do_reset();
    wr(32'h0001_3C3C); wr(32'h0000_3C3C); rd(); wr(32'h0001_3C3C); rd();
    chk("R4 early read key", {31'b0, key}, 32'h0);
  endtask

  task automatic t_foreign();
    do_reset();
    wr(32'h0001_8001);
    acc(0, 1, 2'b10, 32'h0000_FFFF);
    chk("R9 foreign write", rdata, 32'h0000_8001);
    wr(32'h0000_8001);
    acc(0, 0, 2'b01, '0);
    wr(32'h0001_8001);
    acc(0, 1, 2'b00, 32'h0001_0000);
    rd();
    chk("R9 interleaved lock", {31'b0, key}, 32'h1);
    chk("R9 mask", {16'b0, mask}, 32'h0000_8001);
  endtask

  task automatic t_stage();
    do_reset();
    wr(32'hFFFC_0F0F);
    chk("R1 rsv zero", rdata, 32'h0000_0F0F);
    chk("R7 unlocked mask", {16'b0, mask}, 32'h0);
    wr(32'h0000_1234);
    chk("R6 stage", rdata, 32'h0000_1234);
  endtask

  initial begin
    t_reset();
    t_good();
    t_sticky();
    t_mask_change();
    t_narrow();
    t_order();
    t_foreign();
    t_stage();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule